// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one synchronous DRAM read or write burst, one address per clock. A controller pulses a start strobe together with a starting column, a burst length code and an ordering select. From the next cycle on, the block walks through the aligned block of 2, 4 or 8 words that holds the starting column. It uses either a sequential order that wraps inside the block or an interleaved order that XORs the beat number into the low bits.

A hold input freezes the walk while the memory clock is suspended. A flag marks the final address. A length code that the block does not support, including the full-page code, is refused: the block reports an error pulse and issues no address. Bank, row, command timing and data handling stay with the surrounding controller.

Top module: `col_burst_gen`

## Requirements
- R1: After reset, busy_o, last_o and err_o are low and col_o is zero.
- R2: A start strobe taken while idle with a legal length code raises busy_o in the next cycle, and col_o then equals the starting column.
- R3: The length code selects 2 words (3'b001), 4 words (3'b010) or 8 words (3'b011). With interleave_i low, beat n carries the offset (s + n) mod L within the aligned block, where s is the start offset in the block and L is the length.
- R4: With interleave_i high, beat n carries the offset s XOR n within the aligned block.
- R5: Only the low log2(L) column bits change during a burst; all higher column bits keep their starting values.
- R6: For a 2-word burst, the sequential and interleaved orders give the same addresses.
- R7: last_o is high exactly while the final address is shown. When hold_i is low in that cycle, busy_o falls in the next cycle.
- R8: While hold_i is high during a burst, col_o, last_o and the burst progress stay frozen. The walk resumes from the same beat when hold_i falls.
- R9: A start strobe that arrives while busy_o is high is ignored. The running burst continues unchanged, and no new burst follows.
- R10: A start strobe taken while idle with any other length code (3'b000, 3'b1xx; 3'b111 requests a full page) raises err_o for exactly one cycle, and busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | COL_W | Starting column address |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| hold_i | input | 1 | Freezes the burst while high (clock suspend) |
| col_o | output | COL_W | Current column address, zero when idle |
| busy_o | output | 1 | A burst address is on col_o |
| last_o | output | 1 | col_o carries the final address of the burst |
| err_o | output | 1 | One-cycle pulse for a refused length code |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a running burst. It has to arrive with a different column and length, and the block must neither restart nor queue it. The bench raises such a strobe at a known beat of an 8-word burst and checks the rest of the original sequence and the idle cycle after it. A hold is also placed on a mid-burst beat and another on the final beat, to show that the last flag stays frozen and the end is deferred.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

  localparam logic [2:0] LEN2 = 3'b001;
  localparam logic [2:0] LEN4 = 3'b010;
  localparam logic [2:0] LEN8 = 3'b011;

  function automatic logic len_ok(input logic [2:0] code);
    return (code == LEN2) || (code == LEN4) || (code == LEN8);
  endfunction

  // mask of the offset bits that vary; equals the final beat index
  function automatic logic [2:0] low_mask(input logic [2:0] code);
    case (code)
      LEN2:    return 3'b001;
      LEN4:    return 3'b011;
      LEN8:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] seq_low(input logic [2:0] s, input logic [2:0] beat,
                                         input logic [2:0] mask);
    logic [2:0] sum;
    sum = s + beat;
    return (sum & mask) | (s & ~mask);
  endfunction

  function automatic logic [2:0] ilv_low(input logic [2:0] s, input logic [2:0] beat,
                                         input logic [2:0] mask);
    return s ^ (beat & mask);
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import col_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] len_code_i,
  input  logic       hold_i,
  output logic       active_o,
  output logic [2:0] beat_o,
  output logic [2:0] code_o,
  output logic       last_o,
  output logic       err_o,
  output logic       accept_o,
  output logic       advance_o
);

  logic       active_q;
  logic [2:0] beat_q;
  logic [2:0] code_q;
  logic       err_q;
  logic       at_end;

  assign accept_o  = start_i && !active_q && len_ok(len_code_i);
  assign advance_o = active_q && !hold_i;
  assign at_end    = (beat_q == low_mask(code_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= 3'd0;
      code_q   <= 3'd0;
      err_q    <= 1'b0;
    end else begin
      err_q <= start_i && !active_q && !len_ok(len_code_i);
      if (accept_o) begin
        active_q <= 1'b1;
        beat_q   <= 3'd0;
        code_q   <= len_code_i;
      end else if (advance_o) begin
        if (at_end) active_q <= 1'b0;
        else        beat_q   <= beat_q + 3'd1;
      end
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign code_o   = code_q;
  assign last_o   = active_q && at_end;
  assign err_o    = err_q;

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import col_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [2:0]       beat_i,
  input  logic [2:0]       code_i,
  input  logic             ilv_i,
  input  logic             active_i,
  output logic [COL_W-1:0] col_o
);

  localparam int HI_W = COL_W - 3;

  logic [2:0] start_low;
  logic [2:0] mask;
  logic [2:0] low;

  assign start_low = base_i[2:0];
  assign mask      = low_mask(code_i);
  assign low       = ilv_i ? ilv_low(start_low, beat_i, mask)
                           : seq_low(start_low, beat_i, mask);

  generate
    if (HI_W > 0) begin : g_hi
      assign col_o = active_i ? {base_i[COL_W-1:3], low} : '0;
    end else begin : g_lo
      assign col_o = active_i ? low : '0;
    end
  endgenerate

endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
  import col_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             hold_i,
  output logic [COL_W-1:0] col_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             err_o
);

  logic             active;
  logic [2:0]       beat;
  logic [2:0]       code;
  logic             accept_evt;
  logic             advance_evt;
  logic [COL_W-1:0] base_q;
  logic             ilv_q;

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .len_code_i (len_code_i),
    .hold_i     (hold_i),
    .active_o   (active),
    .beat_o     (beat),
    .code_o     (code),
    .last_o     (last_o),
    .err_o      (err_o),
    .accept_o   (accept_evt),
    .advance_o  (advance_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ilv_q  <= 1'b0;
    end else if (accept_evt) begin
      base_q <= start_col_i;
      ilv_q  <= interleave_i;
    end
  end

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i   (base_q),
    .beat_i   (beat),
    .code_i   (code),
    .ilv_i    (ilv_q),
    .active_i (active),
    .col_o    (col_o)
  );

  assign busy_o = active;

endmodule

// File: rtl/col_burst_chk.sv
module col_burst_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             hold_i,
  input logic [COL_W-1:0] col_o,
  input logic             busy_o,
  input logic             last_o,
  input logic             err_o,
  input logic             accept_evt,
  input logic             advance_evt
);

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  p_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy_o);

  p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> busy_o);

  p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && last_o && !hold_i |=> !busy_o);

  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && hold_i |=> busy_o && $stable(col_o) && $stable(last_o));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    advance_evt && !last_o |=> busy_o);

  p_high_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !last_o |=> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |-> !accept_evt);

endmodule

bind col_burst_gen col_burst_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .hold_i      (hold_i),
  .col_o       (col_o),
  .busy_o      (busy_o),
  .last_o      (last_o),
  .err_o       (err_o),
  .accept_evt  (accept_evt),
  .advance_evt (advance_evt)
);

// File: tb/sim_col_burst_gen.sv
`timescale 1ns/1ps
module sim_col_burst_gen;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = 3'b000;
  logic             interleave_i = 1'b0;
  logic             hold_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             busy_o, last_o, err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  col_burst_gen #(.COL_W(COL_W)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] c);
    return (c == 3'b001) ? 2 : (c == 3'b010) ? 4 : 8;
  endfunction

  // expected column for beat n, worked out from the block arithmetic
  function automatic int exp_col(input int s, input int len, input bit ilv, input int n);
    int blk = s - (s % len);
    int off = s % len;
    return ilv ? blk + (off ^ n) : blk + ((off + n) % len);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic launch(input int col, input logic [2:0] code, input bit ilv);
    start_col_i  = col[COL_W-1:0];
    len_code_i   = code;
    interleave_i = ilv;
    start_i      = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  // R2 R3 R4 R5 R7: run a burst and check every beat
  task automatic run_burst(input int col, input logic [2:0] code, input bit ilv,
                           input string tag);
    int len = len_of(code);
    launch(col, code, ilv);
    for (int n = 0; n < len; n++) begin
      chk(busy_o == 1'b1, {tag, " R2 busy"}, int'(busy_o), 1);
      chk(int'(col_o) == exp_col(col, len, ilv, n), {tag, " R3/R4 col"},
          int'(col_o), exp_col(col, len, ilv, n));
      chk(int'(col_o) / 8 == col / 8, {tag, " R5 high bits"}, int'(col_o) / 8, col / 8);
      chk(last_o == (n == len - 1), {tag, " R7 last"}, int'(last_o), int'(n == len - 1));
      tick();
    end
    chk(busy_o == 1'b0, {tag, " R7 end"}, int'(busy_o), 0);
  endtask

  task automatic t_reset();
    chk(busy_o == 0 && last_o == 0 && err_o == 0, "R1 flags", int'({busy_o, last_o, err_o}), 0);
    chk(col_o == 0, "R1 col", int'(col_o), 0);
  endtask

  task automatic t_len2_same();
    int a[2];
    launch(13, 3'b001, 1'b0);
    a[0] = int'(col_o); tick(); a[1] = int'(col_o); tick();
    launch(13, 3'b001, 1'b1);
    chk(int'(col_o) == a[0], "R6 beat0", int'(col_o), a[0]); tick();
    chk(int'(col_o) == a[1], "R6 beat1", int'(col_o), a[1]); tick();
    chk(a[0] == 13 && a[1] == 12, "R6 values", a[0] * 100 + a[1], 1312);
  endtask

  task automatic t_hold();
    int c1;
    launch(45, 3'b010, 1'b1);       // offsets 1,0,3,2 in block 44
    tick();
    c1 = int'(col_o);
    hold_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(int'(col_o) == c1 && last_o == 0 && busy_o == 1, "R8 frozen", int'(col_o), c1);
    end
    hold_i = 1'b0;
    tick();
    chk(int'(col_o) == 47, "R8 resume", int'(col_o), 47);
    tick();
    chk(int'(col_o) == 46 && last_o == 1, "R8 last beat", int'(col_o), 46);
    hold_i = 1'b1;                  // hold on the final beat
    tick();
    chk(busy_o == 1 && last_o == 1 && int'(col_o) == 46, "R8 hold last", int'(busy_o), 1);
    hold_i = 1'b0;
    tick();
    chk(busy_o == 0, "R7 end after hold", int'(busy_o), 0);
  endtask

  task automatic t_busy_ignore();
    launch(64 + 3, 3'b011, 1'b0);
    tick(); tick();                 // now at beat 2
    start_col_i = 10'h155; len_code_i = 3'b001; interleave_i = 1'b1; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int n = 3; n < 8; n++) begin
      chk(int'(col_o) == exp_col(67, 8, 1'b0, n), "R9 continue", int'(col_o),
          exp_col(67, 8, 1'b0, n));
      tick();
    end
    chk(busy_o == 0, "R9 no queued burst", int'(busy_o), 0);
    tick();
    chk(busy_o == 0, "R9 still idle", int'(busy_o), 0);
  endtask

  task automatic t_illegal(input logic [2:0] code);
    launch(20, code, 1'b0);
    chk(err_o == 1 && busy_o == 0, "R10 error pulse", int'({err_o, busy_o}), 2);
    tick();
    chk(err_o == 0 && busy_o == 0, "R10 pulse ends", int'({err_o, busy_o}), 0);
    chk(col_o == 0, "R10 no address", int'(col_o), 0);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    run_burst(2,   3'b010, 1'b0, "seq4");
    run_burst(5,   3'b011, 1'b1, "ilv8");
    run_burst(519, 3'b011, 1'b0, "seq8");
    run_burst(900, 3'b001, 1'b1, "ilv2");
    t_len2_same();
    t_hold();
    t_busy_ignore();
    t_illegal(3'b111);
    t_illegal(3'b000);
    t_illegal(3'b100);
    run_burst(1023, 3'b010, 1'b1, "ilv4 after errors");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule